// File: doc/BRIEF.md
# Bit-Sliced Arithmetic Logic Unit

A purely combinational arithmetic logic unit built by replicating one 1-bit slice across the operand width (32 by default). Each slice can invert either operand, and it holds an AND gate, an OR gate, a full adder and a four-way output selector. The slices are chained through their adder carries. The most significant slice also returns its sum bit as a "set" signal into the bottom slice, and this is how a less-than compare is produced.

A 4-bit control word drives the unit and splits into three fields. Bit 3 inverts operand a. Bit 2 inverts operand b and also supplies the carry into bit 0. Bits 1:0 choose which slice output drives the result. Subtract, less-than and NOR therefore reuse the same adder and AND paths as add and AND. The unit also reports a zero flag and the carry out of the top slice. The unit holds no state, so its outputs follow its inputs within the same cycle.

Top module: `bitslice_alu`

## Requirements
- R1: Control 4'b0000 gives result = a AND b.
- R2: Control 4'b0001 gives result = a OR b.
- R3: Control 4'b0010 gives result = low WIDTH bits of a + b, and carry_out = bit WIDTH of that sum.
- R4: Control 4'b0110 gives result = a - b in two's complement, computed as a + NOT b + 1. carry_out is the carry of that sum, so it is 1 exactly when a >= b as unsigned numbers.
- R5: Control 4'b0111 gives result bit 0 = bit WIDTH-1 of the WIDTH-bit difference a - b, and all other result bits 0. No overflow correction is applied: a = 0x80000000 with b = 1 yields 0.
- R6: Control 4'b1100 gives result = NOT (a OR b).
- R7: zero is 1 exactly when every result bit is 0.
- R8: Any other control value still follows the field split. Let ea = a, inverted when bit 3 is set. Let eb = b, inverted when bit 2 is set. Let cin = bit 2. Bits 1:0 then select ea AND eb (00), ea OR eb (01), the sum bits of ea + eb + cin (10), or the set path (11). Examples: 4'b1101 gives NAND, 4'b0100 gives a AND NOT b.
- R9: For every control value, carry_out is bit WIDTH of ea + eb + cin, with ea, eb and cin as defined in R8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| ctrl | input | 4 | Invert-a, invert-b / carry-in, 2-bit result select |
| result | output | WIDTH | Selected slice outputs |
| zero | output | 1 | High when result is all zeros |
| carry_out | output | 1 | Carry out of the top slice |

## Verification
The embedded assertions are immediate checks evaluated whenever the inputs settle. They assume that every operand and control bit is a known 0 or 1, and that each vector is held long enough for the carry chain to resolve before the outputs are compared. The stimulus keeps to this. Inputs are driven just after a rising clock edge from fully defined constants or random values. They are then held unchanged until the monitor samples on the falling edge, half a cycle later.

// File: rtl/bitslice_alu.sv
module bitslice_alu #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [3:0]       ctrl,
  output logic [WIDTH-1:0] result,
  output logic             zero,
  output logic             carry_out
);

  localparam int MSB = WIDTH - 1;

  logic set_bit;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    logic ai, bi, cin, cout, sum, less;

    assign ai = op_a[i] ^ ctrl[3];
    assign bi = op_b[i] ^ ctrl[2];

    if (i == 0) begin : g_first
      assign cin  = ctrl[2];
      assign less = set_bit;
    end else begin : g_rest
      assign cin  = g_slice[i-1].cout;
      assign less = 1'b0;
    end

    assign sum  = ai ^ bi ^ cin;
    assign cout = (ai & bi) | (ai & cin) | (bi & cin);

    always_comb begin
      unique case (ctrl[1:0])
        2'b00:   result[i] = ai & bi;
        2'b01:   result[i] = ai | bi;
        2'b10:   result[i] = sum;
        default: result[i] = less;
      endcase
    end
  end

  assign set_bit   = g_slice[MSB].sum;
  assign carry_out = g_slice[MSB].cout;
  assign zero      = ~|result;

  logic [WIDTH:0] chk_add, chk_sub;
  always_comb begin
    chk_add = {1'b0, op_a} + {1'b0, op_b};
    chk_sub = {1'b0, op_a} + {1'b0, ~op_b} + {{WIDTH{1'b0}}, 1'b1};
    if (!$isunknown({op_a, op_b, ctrl})) begin
      if (ctrl == 4'b0000) p_and_r1: assert (result == (op_a & op_b));
      if (ctrl == 4'b0001) p_or_r2: assert (result == (op_a | op_b));
      if (ctrl == 4'b0010) p_add_r3: assert ({carry_out, result} == chk_add);
      if (ctrl == 4'b0110) p_sub_r4: assert (result == chk_sub[MSB:0] && carry_out == (op_a >= op_b));
      if (ctrl == 4'b0110) p_eq_zero_r7: assert (zero == (op_a == op_b));
      if (ctrl == 4'b0111) p_slt_r5: assert (result[MSB:1] == '0 && result[0] == chk_sub[MSB]);
      if (ctrl == 4'b1100) p_nor_r6: assert (result == ~(op_a | op_b));
      if (ctrl == 4'b1101) p_nand_r8: assert (result == ~(op_a & op_b));
    end
  end

endmodule

// File: tb/test_bitslice_alu.sv
`timescale 1ns/1ps
module test_bitslice_alu;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [W-1:0] a, b, res;
  logic [3:0]   ctrl;
  logic         zero, cout;

  bitslice_alu #(.WIDTH(W)) i_bitslice_alu (
    .op_a(a), .op_b(b), .ctrl(ctrl),
    .result(res), .zero(zero), .carry_out(cout)
  );

  typedef struct {
    logic [3:0]   c;
    logic [W-1:0] a, b, r;
    logic         z, co;
    string        tag;
  } item_t;

  item_t sb[$];
  int checks = 0, errors = 0;
  bit done = 0;

  function automatic item_t model(input logic [3:0] c, input logic [W-1:0] x, input logic [W-1:0] y, input string tag);
    item_t it;
    logic [W-1:0] ea, eb;
    logic [W:0]   s, d;
    ea = c[3] ? ~x : x;
    eb = c[2] ? ~y : y;
    s  = {1'b0, ea} + {1'b0, eb} + {{W{1'b0}}, c[2]};
    d  = {1'b0, x} - {1'b0, y};
    it.c = c; it.a = x; it.b = y; it.tag = tag;
    it.co = s[W];
    case (c)
      4'b0000: it.r = x & y;
      4'b0001: it.r = x | y;
      4'b0010: it.r = x + y;
      4'b0110: it.r = x - y;
      4'b0111: it.r = {{(W-1){1'b0}}, d[W-1]};
      4'b1100: it.r = ~(x | y);
      default: case (c[1:0])
        2'b00:   it.r = ea & eb;
        2'b01:   it.r = ea | eb;
        2'b10:   it.r = s[W-1:0];
        default: it.r = {{(W-1){1'b0}}, s[W-1]};
      endcase
    endcase
    if (c == 4'b0110) it.co = (x >= y);
    it.z = (it.r == '0);
    return it;
  endfunction

  task automatic drive(input logic [3:0] c, input logic [W-1:0] x, input logic [W-1:0] y, input string tag);
    @(posedge clk);
    #1;
    ctrl = c; a = x; b = y;
    sb.push_back(model(c, x, y, tag));
  endtask

  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t e;
      e = sb.pop_front();
      checks++;
      if (res !== e.r || zero !== e.z || cout !== e.co) begin
        errors++;
        $display("FAIL %s ctrl=%b a=%h b=%h: got res=%h zero=%b cout=%b, expected res=%h zero=%b cout=%b",
                 e.tag, e.c, e.a, e.b, res, zero, cout, e.r, e.z, e.co);
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    ctrl = 4'b0000; a = '0; b = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    drive(4'b0000, '0, '0, "R7 reset idle zero");
    drive(4'b0000, 32'hF0F0_1234, 32'hFF00_FF00, "R1 and");
    drive(4'b0001, 32'hF0F0_1234, 32'h0F00_0001, "R2 or");
    drive(4'b0010, 32'h0000_0001, 32'h0000_0002, "R3 add small");
    drive(4'b0010, 32'hFFFF_FFFF, 32'h0000_0001, "R3 add carry wrap R7");
    drive(4'b0010, 32'h7FFF_FFFF, 32'h0000_0001, "R3 add to sign");
    drive(4'b0110, 32'h0000_0005, 32'h0000_0003, "R4 sub ge");
    drive(4'b0110, 32'h0000_0003, 32'h0000_0005, "R4 sub borrow");
    drive(4'b0110, 32'h1234_5678, 32'h1234_5678, "R4 sub equal R7");
    drive(4'b0111, 32'h0000_0003, 32'h0000_0005, "R5 slt true");
    drive(4'b0111, 32'h0000_0005, 32'h0000_0003, "R5 slt false");
    drive(4'b0111, 32'hFFFF_FFFF, 32'h0000_0001, "R5 slt negative");
    drive(4'b0111, 32'h8000_0000, 32'h0000_0001, "R5 slt no overflow fix");
    drive(4'b0111, 32'h0000_0007, 32'h0000_0007, "R5 slt equal");
    drive(4'b1100, 32'h0000_0000, 32'h0000_0000, "R6 nor all ones");
    drive(4'b1100, 32'hAAAA_0000, 32'h5555_000F, "R6 nor mix");
    drive(4'b1101, 32'hFFFF_0000, 32'hFF00_FF00, "R8 nand");
    drive(4'b0100, 32'hFFFF_0000, 32'hFF00_FF00, "R8 a and not b");
    drive(4'b1010, 32'h0000_0010, 32'h0000_0003, "R8 not a plus b R9");
    drive(4'b0011, 32'h0000_0003, 32'h0000_0005, "R8 set no invert");
    for (int k = 0; k < 600; k++) begin
      logic [3:0] c;
      logic [W-1:0] x, y;
      c = 4'($urandom_range(0, 15));
      x = $urandom;
      y = (k % 7 == 0) ? x : $urandom;
      drive(c, x, y, "R9 random carry and result");
    end
    @(posedge clk);
    @(posedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule